// File: doc/BRIEF.md
# Ratiometric Single-Slope Conversion Sequencer

This block is the digital half of a single-slope integrating converter that calibrates itself on every conversion. A free-running timer produces the integrator reset pulse. The pulse has a fixed period and width, and conversion activity never alters it. Each period therefore holds one ramp: it starts on the first cycle after the reset pulse and ends on the last cycle of the period.

When a conversion is requested, the sequencer walks a three-way analog multiplexer through three sources: the zero source, then the full-scale reference, then the unknown input. All selects are dropped for a guard interval before each new select is raised. For each source the sequencer waits for a ramp that starts after the select is up. It then counts the clock cycles in which the comparator width pulse is high inside that ramp.

From the three counts it forms a signed ratio scaled by a constant, (Cin − Czero)·K / (Cref − Czero), using a sequential restoring divider. It presents the result with a one-cycle valid strobe and holds the value until the next result. A ramp in which the comparator never trips marks the conversion as overrange. A reference count that does not exceed the zero count marks it as a calibration error. Either condition skips the division.

Top module: `slope_ratio_seq`

## Requirements
- R1: `integ_rst_o` repeats with period RST_PERIOD, counted from reset release. It is high for the first RST_WIDTH cycles of each period and low for the rest, whether or not a conversion is running.
- R2: A `conv_i` pulse while idle starts a conversion. `mux_sel_o` is always one-hot or zero, and it selects bit 0 (zero), then bit 1 (reference), then bit 2 (input), each exactly once per conversion.
- R3: Two different selects are never high in consecutive cycles. Before any select rises, `mux_sel_o` has been zero for at least GUARD_CYC cycles.
- R4: Each source is measured on the first ramp whose start cycle (the first cycle with `integ_rst_o` low) finds that source's select already high. A ramp in progress when the select rises is not used.
- R5: A count is the number of cycles of the measured ramp in which `width_i` is high. `width_i` has no effect while `integ_rst_o` is high.
- R6: The result is (Cin − Czero)·SCALE_K / (Cref − Czero), truncated toward zero, as a two's-complement NUM_W-bit value. It is negative when Cin < Czero.
- R7: `valid_o` is high for exactly one cycle per conversion. `result_o`, `ovr_o` and `cal_err_o` change only in a cycle where `valid_o` is high.
- R8: If `width_i` is still high in the last cycle of any measured ramp, that count saturates at RST_PERIOD − RST_WIDTH. `ovr_o` is then 1 and `result_o` is 0 with the valid strobe.
- R9: If Cref ≤ Czero, `cal_err_o` is 1 and `result_o` is 0 with the valid strobe.
- R10: `conv_i` pulses during a running conversion are ignored: no extra select sequence and no extra valid strobe follow.
- R11: `valid_o` rises NUM_W + 4 cycles after the last cycle of the input ramp when the division runs, and 3 cycles after it when the division is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Conversion request, sampled while idle |
| width_i | input | 1 | Comparator width pulse, high from ramp start until the trip |
| integ_rst_o | output | 1 | Integrator reset pulse train |
| mux_sel_o | output | 3 | One-hot source select: bit 0 zero, bit 1 reference, bit 2 input |
| result_o | output | NUM_W | Signed scaled ratio |
| valid_o | output | 1 | One-cycle strobe for a new result |
| ovr_o | output | 1 | Overrange flag of the last conversion |
| cal_err_o | output | 1 | Calibration error flag of the last conversion |

## Verification
The bench keeps its own count of clock cycles since reset release. It predicts the reset pulse level for every cycle and compares it away from the clock edge. It models the comparator from a count per source, latched from the select seen at each ramp start, so a measurement taken on the wrong ramp yields a wrong ratio.

Each result is due a fixed number of cycles after the last cycle of the input ramp: NUM_W + 4 cycles when the division runs and 3 cycles when it is skipped. The bench checks the exact cycle distance, together with the value and flags computed from the programmed counts.

// File: rtl/slope_ratio_pkg.sv
package slope_ratio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_ACQ,
    ST_CALC,
    ST_DIV
  } seq_state_e;

  localparam int unsigned SRC_ZERO = 0;
  localparam int unsigned SRC_REF  = 1;
  localparam int unsigned SRC_IN   = 2;
  localparam int unsigned N_SRC    = 3;
endpackage

// File: rtl/ramp_timer.sv
module ramp_timer #(
  parameter int unsigned PERIOD = 64,
  parameter int unsigned PULSE  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic integ_rst_o,
  output logic ramp_start_o,
  output logic ramp_last_o
);
  localparam int unsigned PH_W = $clog2(PERIOD);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else if (ph_q == PH_W'(PERIOD - 1)) ph_q <= '0;
    else ph_q <= ph_q + 1'b1;
  end

  assign integ_rst_o  = ph_q < PH_W'(PULSE);
  assign ramp_start_o = ph_q == PH_W'(PULSE);
  assign ramp_last_o  = ph_q == PH_W'(PERIOD - 1);
endmodule

// File: rtl/slope_counter.sv
module slope_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             ramp_start_i,
  input  logic             ramp_last_i,
  input  logic             width_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovr_o,
  output logic             done_o
);
  logic             active_q, done_q, ovr_q;
  logic [CNT_W-1:0] acc_q, count_q, acc_nx;

  assign acc_nx = acc_q + CNT_W'(width_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      acc_q    <= '0;
      count_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        // a ramp already running is never picked up
        if (arm_i && ramp_start_i) begin
          active_q <= 1'b1;
          acc_q    <= CNT_W'(width_i);
        end
      end else if (ramp_last_i) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
        count_q  <= acc_nx;
        ovr_q    <= width_i;
      end else begin
        acc_q <= acc_nx;
      end
    end
  end

  assign count_o = count_q;
  assign ovr_o   = ovr_q;
  assign done_o  = done_q;
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
  parameter int unsigned NUM_W = 48,
  parameter int unsigned DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             done_o
);
  localparam int unsigned STEP_W = $clog2(NUM_W + 1);

  logic              busy_q, done_q;
  logic [STEP_W-1:0] step_q;
  logic [DEN_W-1:0]  rem_q, den_q, rem_sub;
  logic [NUM_W-1:0]  quo_q;
  logic [DEN_W:0]    shifted;
  logic              take;

  assign shifted = {rem_q, quo_q[NUM_W-1]};
  assign take    = shifted >= {1'b0, den_q};
  assign rem_sub = shifted[DEN_W-1:0] - den_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          step_q <= STEP_W'(NUM_W);
          rem_q  <= '0;
          den_q  <= den_i;
          quo_q  <= num_i;
        end
      end else begin
        rem_q  <= take ? rem_sub : shifted[DEN_W-1:0];
        quo_q  <= {quo_q[NUM_W-2:0], take};
        step_q <= step_q - 1'b1;
        if (step_q == STEP_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/slope_ratio_seq.sv
module slope_ratio_seq
  import slope_ratio_pkg::*;
#(
  parameter int unsigned RST_PERIOD = 64,
  parameter int unsigned RST_WIDTH  = 8,
  parameter int unsigned GUARD_CYC  = 3,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SCALE_K    = 10_000_000,
  parameter int unsigned NUM_W      = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic             width_i,
  output logic             integ_rst_o,
  output logic [2:0]       mux_sel_o,
  output logic [NUM_W-1:0] result_o,
  output logic             valid_o,
  output logic             ovr_o,
  output logic             cal_err_o
);
  localparam int unsigned GD_W = $clog2(GUARD_CYC + 1);

  seq_state_e       state_q;
  logic [1:0]       src_q;
  logic [GD_W-1:0]  gcnt_q;
  logic [CNT_W-1:0] cnt_q [N_SRC];
  logic             ovr_acc_q, neg_q, valid_q, ovr_q, err_q;
  logic [NUM_W-1:0] result_q;

  logic             ramp_start, ramp_last;
  logic [CNT_W-1:0] sc_count;
  logic             sc_ovr, sc_done;
  logic [CNT_W:0]   dif, mag;
  logic [NUM_W-1:0] num, quo, quo_neg;
  logic [CNT_W-1:0] den;
  logic             cal_bad, div_start, div_done;

  ramp_timer #(.PERIOD(RST_PERIOD), .PULSE(RST_WIDTH)) u_timer (
    .clk_i, .rst_ni,
    .integ_rst_o  (integ_rst_o),
    .ramp_start_o (ramp_start),
    .ramp_last_o  (ramp_last)
  );

  slope_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i, .rst_ni,
    .arm_i        (state_q == ST_ACQ),
    .ramp_start_i (ramp_start),
    .ramp_last_i  (ramp_last),
    .width_i      (width_i),
    .count_o      (sc_count),
    .ovr_o        (sc_ovr),
    .done_o       (sc_done)
  );

  // sign-magnitude numerator, positive denominator
  assign dif       = {1'b0, cnt_q[SRC_IN]} - {1'b0, cnt_q[SRC_ZERO]};
  assign mag       = dif[CNT_W] ? (~dif + 1'b1) : dif;
  assign num       = NUM_W'(mag) * NUM_W'(SCALE_K);
  assign den       = cnt_q[SRC_REF] - cnt_q[SRC_ZERO];
  assign cal_bad   = cnt_q[SRC_REF] <= cnt_q[SRC_ZERO];
  assign div_start = (state_q == ST_CALC) && !ovr_acc_q && !cal_bad;
  assign quo_neg   = ~quo + 1'b1;

  ratio_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk_i, .rst_ni,
    .start_i (div_start),
    .num_i   (num),
    .den_i   (den),
    .quo_o   (quo),
    .done_o  (div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      src_q     <= '0;
      gcnt_q    <= '0;
      ovr_acc_q <= 1'b0;
      neg_q     <= 1'b0;
      valid_q   <= 1'b0;
      ovr_q     <= 1'b0;
      err_q     <= 1'b0;
      result_q  <= '0;
      for (int i = 0; i < N_SRC; i++) cnt_q[i] <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (conv_i) begin
          src_q     <= 2'(SRC_ZERO);
          gcnt_q    <= GD_W'(GUARD_CYC - 1);
          ovr_acc_q <= 1'b0;
          state_q   <= ST_GUARD;
        end
        ST_GUARD: begin
          if (gcnt_q == '0) state_q <= ST_ACQ;
          else gcnt_q <= gcnt_q - 1'b1;
        end
        ST_ACQ: if (sc_done) begin
          cnt_q[src_q] <= sc_count;
          ovr_acc_q    <= ovr_acc_q | sc_ovr;
          if (src_q == 2'(SRC_IN)) begin
            state_q <= ST_CALC;
          end else begin
            src_q   <= src_q + 1'b1;
            gcnt_q  <= GD_W'(GUARD_CYC - 1);
            state_q <= ST_GUARD;
          end
        end
        ST_CALC: begin
          neg_q <= dif[CNT_W];
          if (ovr_acc_q || cal_bad) begin
            result_q <= '0;
            ovr_q    <= ovr_acc_q;
            err_q    <= cal_bad;
            valid_q  <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            state_q <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          result_q <= neg_q ? quo_neg : quo;
          ovr_q    <= 1'b0;
          err_q    <= 1'b0;
          valid_q  <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mux_sel_o = (state_q == ST_ACQ) ? (3'b001 << src_q) : 3'b000;
  assign result_o  = result_q;
  assign valid_o   = valid_q;
  assign ovr_o     = ovr_q;
  assign cal_err_o = err_q;
endmodule

// File: rtl/slope_ratio_seq_chk.sv
module slope_ratio_seq_chk #(
  parameter int unsigned RST_PERIOD = 64,
  parameter int unsigned RST_WIDTH  = 8,
  parameter int unsigned GUARD_CYC  = 3,
  parameter int unsigned NUM_W      = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             integ_rst_o,
  input logic [2:0]       mux_sel_o,
  input logic [NUM_W-1:0] result_o,
  input logic             valid_o,
  input logic             ovr_o,
  input logic             cal_err_o
);
  localparam int unsigned PH_W = $clog2(RST_PERIOD);
  localparam int unsigned ZR_W = $clog2(GUARD_CYC + 1);

  logic [PH_W-1:0] ph_q;
  logic [ZR_W-1:0] zrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      zrun_q <= '0;
    end else begin
      ph_q <= (ph_q == PH_W'(RST_PERIOD - 1)) ? '0 : ph_q + 1'b1;
      if (mux_sel_o != 3'b000) zrun_q <= '0;
      else if (zrun_q != ZR_W'(GUARD_CYC)) zrun_q <= zrun_q + 1'b1;
    end
  end

  p_rst_cadence_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    integ_rst_o == (ph_q < PH_W'(RST_WIDTH)));

  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mux_sel_o));

  p_no_direct_switch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o != 3'b000 && $past(mux_sel_o) != 3'b000) |-> mux_sel_o == $past(mux_sel_o));

  p_guard_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o != 3'b000 && $past(mux_sel_o) == 3'b000) |-> zrun_q == ZR_W'(GUARD_CYC));

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(result_o) && $stable(ovr_o) && $stable(cal_err_o)));

  p_ovr_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovr_o) |-> result_o == '0);

  p_err_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cal_err_o) |-> result_o == '0);
endmodule

bind slope_ratio_seq slope_ratio_seq_chk #(
  .RST_PERIOD (RST_PERIOD),
  .RST_WIDTH  (RST_WIDTH),
  .GUARD_CYC  (GUARD_CYC),
  .NUM_W      (NUM_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .integ_rst_o (integ_rst_o),
  .mux_sel_o   (mux_sel_o),
  .result_o    (result_o),
  .valid_o     (valid_o),
  .ovr_o       (ovr_o),
  .cal_err_o   (cal_err_o)
);

// File: tb/slope_ratio_seq_tb.sv
module slope_ratio_seq_tb_top;
  localparam int P     = 64;
  localparam int W     = 8;
  localparam int G     = 3;
  localparam int NUM_W = 48;
  localparam longint K = 10_000_000;
  localparam int RAMP  = P - W;
  localparam int IDLE_C = 30;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic conv_i = 1'b0;
  logic width_i = 1'b0;
  logic integ_rst_o, valid_o, ovr_o, cal_err_o;
  logic [2:0] mux_sel_o;
  logic [NUM_W-1:0] result_o;

  slope_ratio_seq dut_i (
    .clk_i, .rst_ni, .conv_i, .width_i,
    .integ_rst_o, .mux_sel_o, .result_o, .valid_o, .ovr_o, .cal_err_o
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int k = 0;
  int cz, cf, cx, cur_c;
  bit junk = 1'b0;
  logic [2:0] cur_sel = 3'b000, prev_sel = 3'b000;
  logic [NUM_W-1:0] prev_res = '0;
  logic prev_ovr = 1'b0, prev_err = 1'b0;
  int zrun = 0, last_ex_k = 0, valid_cnt = 0;
  logic [2:0] seq_q[$];
  longint exp_res;
  bit exp_ovr, exp_err;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) if (rst_ni) k <= k + 1;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk(integ_rst_o == 1'b1 && mux_sel_o == 3'b000, "R1 reset state", integ_rst_o, 1);
      chk(valid_o == 1'b0 && result_o == '0 && !ovr_o && !cal_err_o, "R7 reset state", valid_o, 0);
    end else begin
      int ph;
      ph = k % P;
      if (ph == W) begin
        cur_sel = mux_sel_o;
        case (mux_sel_o)
          3'b001:  cur_c = cz;
          3'b010:  cur_c = cf;
          3'b100:  cur_c = cx;
          default: cur_c = IDLE_C;
        endcase
      end
      width_i = (ph >= W) ? (ph < W + cur_c) : junk;
      chk(integ_rst_o == (ph < W), "R1 reset cadence", integ_rst_o, ph < W);
      chk($onehot0(mux_sel_o), "R2 select one-hot", mux_sel_o, 0);
      if (mux_sel_o != 3'b000 && prev_sel == 3'b000) begin
        chk(zrun >= G, "R3 guard gap", zrun, G);
        seq_q.push_back(mux_sel_o);
      end
      if (mux_sel_o != 3'b000 && prev_sel != 3'b000)
        chk(mux_sel_o == prev_sel, "R3 direct switch", mux_sel_o, prev_sel);
      zrun = (mux_sel_o == 3'b000) ? zrun + 1 : 0;
      if (ph == P - 1 && cur_sel == 3'b100) last_ex_k = k;
      if (valid_o) begin
        valid_cnt++;
        chk(seq_q.size() == 3 && seq_q[0] == 3'b001 && seq_q[1] == 3'b010 && seq_q[2] == 3'b100,
            "R2 source order", seq_q.size(), 3);
        chk(longint'($signed(result_o)) == exp_res, "R4 R5 R6 result",
            longint'($signed(result_o)), exp_res);
        chk(ovr_o == exp_ovr, "R8 overrange flag", ovr_o, exp_ovr);
        chk(cal_err_o == exp_err, "R9 calibration flag", cal_err_o, exp_err);
        chk(k - last_ex_k == ((exp_ovr || exp_err) ? 3 : NUM_W + 4), "R11 latency",
            k - last_ex_k, (exp_ovr || exp_err) ? 3 : NUM_W + 4);
        seq_q.delete();
      end else begin
        chk(result_o == prev_res && ovr_o == prev_ovr && cal_err_o == prev_err,
            "R7 hold", longint'($signed(result_o)), longint'($signed(prev_res)));
      end
      prev_sel = mux_sel_o;
      prev_res = result_o;
      prev_ovr = ovr_o;
      prev_err = cal_err_o;
    end
  end

  task automatic run_conv(int z, int f, int x, int at_ph, bit jk, bit extra);
    int ez, ef, ex, v0, lim;
    ez = (z > RAMP) ? RAMP : z;
    ef = (f > RAMP) ? RAMP : f;
    ex = (x > RAMP) ? RAMP : x;
    exp_ovr = (z >= RAMP) || (f >= RAMP) || (x >= RAMP);
    exp_err = ef <= ez;
    exp_res = (exp_ovr || exp_err) ? 0 : (longint'(ex - ez) * K) / longint'(ef - ez);
    cz = z; cf = f; cx = x; junk = jk;
    do @(negedge clk_i); while (k % P != at_ph);
    v0 = valid_cnt;
    conv_i = 1'b1;
    @(negedge clk_i) conv_i = 1'b0;
    if (extra) begin
      repeat (80) @(negedge clk_i);
      conv_i = 1'b1;
      @(negedge clk_i) conv_i = 1'b0;
    end
    lim = 0;
    while (valid_cnt == v0 && lim < 2000) begin
      @(negedge clk_i);
      lim++;
    end
    chk(valid_cnt == v0 + 1, "R7 one result per request", valid_cnt - v0, 1);
    if (extra) begin
      repeat (2 * P) @(negedge clk_i);
      chk(valid_cnt == v0 + 1 && seq_q.size() == 0, "R10 request ignored while busy",
          seq_q.size(), 0);
    end
    junk = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    run_conv(5, 45, 25, 20, 1'b0, 1'b0);
    run_conv(10, 50, 4, 3, 1'b1, 1'b0);
    run_conv(3, 44, 20, 40, 1'b0, 1'b1);
    run_conv(7, 51, 51, 60, 1'b1, 1'b0);
    run_conv(20, 20, 30, 15, 1'b0, 1'b0);
    run_conv(30, 12, 5, 33, 1'b0, 1'b0);
    run_conv(4, 40, 60, 9, 1'b0, 1'b0);
    run_conv(6, 50, 0, 10, 1'b1, 1'b0);
    run_conv(1, 55, 54, 50, 1'b0, 1'b0);
    repeat (5) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", k, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule